// File: doc/BRIEF.md
# EPROM Pulse-and-Verify Programming Sequencer

This block writes a byte image into a UV-erasable or one-time-programmable EPROM. It also confirms the result. A single `start` pulse begins a run. The sequencer switches the programming supply and the raised core supply on through select outputs. It then steps through every address and asks a byte source for the data of each one. Every byte that holds a zero gets a series of fixed-width program strobes on the active-low chip enable. After each strobe the sequencer reads the byte back with output enable low and chip enable high, and compares it with the source data. A byte that matches moves the run on to the next address. A byte that does not match gets another strobe. A byte that never matches within the strobe limit ends the run with a failure flag.

Once the last address has been written, the programming supply is turned off. The sequencer then reads the whole array twice against the source: first at a high-margin core supply, then at a low-margin one. Any mismatch in either pass fails the run. A failing run leaves its address, its strobe count and its stage in status outputs. Every delay is a cycle count derived from a clock-frequency parameter, so the same RTL holds the required microsecond and nanosecond windows at any clock rate.

Top module: `eprom_prog_seq`

## Requirements
- R1: After reset: `dev_e_n`=1, `dev_g_n`=1, `vpp_en`=0, `vcc_sel`=0, `dq_oe`=0, `src_req`=0, `done`=0, `fail`=0.
- R2: `dev_e_n` goes low only while `vpp_en`=1, `vcc_sel`=1 (programming level, 6.25 V), `dev_g_n`=1 and `dq_oe`=1.
- R3: Each program strobe keeps `dev_e_n` low for exactly CLK_KHZ/10 cycles (100 us). That width must fall inside 95 to 105 us.
- R4: Address, write data, `dq_oe` and both supply selects are unchanged for at least 2 us before `dev_e_n` falls. The write data stays driven and unchanged for at least 2 us after `dev_e_n` rises.
- R5: A read-back keeps `dev_e_n` high and `dq_oe` low. The bus is released at least 2 us before `dev_g_n` falls. `dq_in` is sampled only after `dev_g_n` has been low for at least 100 ns. The bus is driven again no sooner than 130 ns after `dev_g_n` rises.
- R6: In the write stage, each read-back that matches moves the run to the next address. Each mismatch triggers one more strobe. A byte that needs N strobes gets exactly N, and each strobe is followed by one read-back.
- R7: A byte that still does not match after MAX_PULSES strobes (default 25) ends the run with `done`=1, `fail`=1, `fail_addr` = that address, `fail_pulses` = MAX_PULSES, `fail_phase`=0. No later address is strobed.
- R8: A source byte of 0xFF gets no strobe. It is read back once and then the run moves on.
- R9: After the last address, two full read passes follow, each covering every address in ascending order with `vpp_en`=0. The first uses `vcc_sel`=2 (6.0 V), the second `vcc_sel`=3 (4.2 V). A mismatch ends the run with `fail`=1, `fail_addr` set and `fail_phase`=1 or 2 for the pass.
- R10: A run that completes sets `done`=1 with `fail`=0, and returns `vpp_en` and `vcc_sel` to 0.
- R11: `src_req` is held with a steady `src_addr` until `src_valid` is seen. `src_data` is taken in the cycle in which both are high. Each address is requested once per stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a run when idle |
| done | output | 1 | Run finished (held until next start) |
| fail | output | 1 | Run ended in failure |
| src_req | output | 1 | Request for the byte at `src_addr` |
| src_addr | output | ADDR_W | Address of the requested byte |
| src_valid | input | 1 | Source byte present |
| src_data | input | DATA_W | Source byte |
| dev_e_n | output | 1 | Device chip enable, active low, used as program strobe |
| dev_g_n | output | 1 | Device output enable, active low |
| vpp_en | output | 1 | Programming supply on |
| vcc_sel | output | 2 | Core supply: 0 nominal 5 V, 1 6.25 V, 2 6.0 V, 3 4.2 V |
| dev_addr | output | ADDR_W | Device address |
| dq_out | output | DATA_W | Write data toward the device |
| dq_oe | output | 1 | Write data driven onto the device bus |
| dq_in | input | DATA_W | Data read from the device |
| fail_addr | output | ADDR_W | Address that failed |
| fail_pulses | output | CNT_W | Strobes applied to the failing byte |
| fail_phase | output | 2 | Stage of failure: 0 write, 1 high-margin pass, 2 low-margin pass |

## Verification
The assertions assume that the source eventually answers a request, and that `dq_in` may hold any value while `dev_g_n` is high. They also assume that `start` arriving outside the idle state is ignored. The bench source answers each request after a random delay of zero to two cycles and drops `src_valid` as soon as the request ends. The bench device model returns a corrupted byte until output enable has been low for more than 100 ns. It needs a random number of strobes per byte. It can also hold one bit stuck at one, or flip a bit at one address only at the lowest supply, which drives the retry-limit path and the low-margin failure path.

// File: rtl/eprom_prog_seq.sv
module eprom_prog_seq #(
  parameter int ADDR_W     = 15,
  parameter int DATA_W     = 8,
  parameter int CLK_KHZ    = 50000,
  parameter int MAX_PULSES = 25,
  localparam int CNT_W     = $clog2(MAX_PULSES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              done,
  output logic              fail,
  output logic              src_req,
  output logic [ADDR_W-1:0] src_addr,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  output logic              dev_e_n,
  output logic              dev_g_n,
  output logic              vpp_en,
  output logic [1:0]        vcc_sel,
  output logic [ADDR_W-1:0] dev_addr,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [CNT_W-1:0]  fail_pulses,
  output logic [1:0]        fail_phase
);

  localparam int T_PULSE = CLK_KHZ / 10;
  localparam int T_PMIN  = (CLK_KHZ * 95) / 1000;
  localparam int T_PMAX  = (CLK_KHZ * 105) / 1000;
  localparam int T_SETUP = (CLK_KHZ * 2 + 999) / 1000;
  localparam int T_GQV   = (CLK_KHZ * 100 + 999999) / 1000000;
  localparam int T_GQZ   = (CLK_KHZ * 130 + 999999) / 1000000;
  localparam int TMR_W   = $clog2(T_PULSE + T_SETUP + T_GQV + 2);
  localparam int CW      = $clog2(T_PMAX + T_SETUP + 2) + 1;

  localparam logic [1:0] VS_NOM  = 2'd0;
  localparam logic [1:0] VS_PROG = 2'd1;
  localparam logic [1:0] VS_HI   = 2'd2;
  localparam logic [1:0] VS_LO   = 2'd3;

  localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};
  localparam logic [DATA_W-1:0] ERASED    = {DATA_W{1'b1}};
  localparam logic [CNT_W-1:0]  MAXP      = CNT_W'(MAX_PULSES);

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_PSETUP, S_PULSE, S_HOLD, S_VGAP, S_VREAD, S_VREL
  } state_t;

  state_t             st;
  logic [TMR_W-1:0]   tmr;
  logic [ADDR_W-1:0]  addr;
  logic [DATA_W-1:0]  byte_q;
  logic [CNT_W-1:0]   npulse;
  logic [1:0]         phase;
  logic               match_q;
  logic               tmr_zero;

  assign tmr_zero = (tmr == '0);
  assign dev_e_n  = (st != S_PULSE);
  assign dev_g_n  = (st != S_VREAD);
  assign dq_oe    = (st == S_PSETUP) || (st == S_PULSE) || (st == S_HOLD);
  assign dq_out   = byte_q;
  assign src_req  = (st == S_FETCH);
  assign src_addr = addr;
  assign dev_addr = addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      tmr         <= '0;
      addr        <= '0;
      byte_q      <= '0;
      npulse      <= '0;
      phase       <= 2'd0;
      match_q     <= 1'b0;
      done        <= 1'b0;
      fail        <= 1'b0;
      vpp_en      <= 1'b0;
      vcc_sel     <= VS_NOM;
      fail_addr   <= '0;
      fail_pulses <= '0;
      fail_phase  <= 2'd0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          done    <= 1'b0;
          fail    <= 1'b0;
          addr    <= '0;
          phase   <= 2'd0;
          vpp_en  <= 1'b1;
          vcc_sel <= VS_PROG;
          st      <= S_FETCH;
        end
        S_FETCH: if (src_valid) begin
          byte_q <= src_data;
          npulse <= '0;
          tmr    <= TMR_W'(T_SETUP - 1);
          st     <= (phase == 2'd0 && src_data != ERASED) ? S_PSETUP : S_VGAP;
        end
        S_PSETUP:
          if (tmr_zero) begin st <= S_PULSE; tmr <= TMR_W'(T_PULSE - 1); end
          else tmr <= tmr - 1'b1;
        S_PULSE:
          if (tmr_zero) begin
            st     <= S_HOLD;
            tmr    <= TMR_W'(T_SETUP - 1);
            npulse <= npulse + CNT_W'(1);
          end else tmr <= tmr - 1'b1;
        S_HOLD:
          if (tmr_zero) begin st <= S_VGAP; tmr <= TMR_W'(T_SETUP - 1); end
          else tmr <= tmr - 1'b1;
        S_VGAP:
          if (tmr_zero) begin st <= S_VREAD; tmr <= TMR_W'(T_GQV); end
          else tmr <= tmr - 1'b1;
        S_VREAD:
          if (tmr_zero) begin
            match_q <= (dq_in == byte_q);
            st      <= S_VREL;
            tmr     <= TMR_W'(T_GQZ - 1);
          end else tmr <= tmr - 1'b1;
        S_VREL:
          if (!tmr_zero) tmr <= tmr - 1'b1;
          else if (match_q) begin
            if (addr != LAST_ADDR) begin
              addr <= addr + ADDR_W'(1);
              st   <= S_FETCH;
            end else if (phase == 2'd2) begin
              st      <= S_IDLE;
              done    <= 1'b1;
              vpp_en  <= 1'b0;
              vcc_sel <= VS_NOM;
            end else begin
              addr    <= '0;
              phase   <= phase + 2'd1;
              vpp_en  <= 1'b0;
              vcc_sel <= (phase == 2'd0) ? VS_HI : VS_LO;
              st      <= S_FETCH;
            end
          end else if (phase == 2'd0 && npulse < MAXP) begin
            st  <= S_PSETUP;
            tmr <= TMR_W'(T_SETUP - 1);
          end else begin
            st          <= S_IDLE;
            done        <= 1'b1;
            fail        <= 1'b1;
            fail_addr   <= addr;
            fail_pulses <= npulse;
            fail_phase  <= phase;
            vpp_en      <= 1'b0;
            vcc_sel     <= VS_NOM;
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  // Timing monitors for the assertions below
  logic [CW-1:0] elow_c, ehigh_c, goff_c, stab_c;
  logic [ADDR_W+DATA_W+3:0] ctl_q;
  wire  [ADDR_W+DATA_W+3:0] ctl_now = {dev_addr, dq_out, dq_oe, vpp_en, vcc_sel};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elow_c  <= '0;
      ehigh_c <= '0;
      goff_c  <= '0;
      stab_c  <= '0;
      ctl_q   <= '0;
    end else begin
      elow_c  <= dev_e_n ? '0 : elow_c + CW'(1);
      ehigh_c <= !dev_e_n ? '0 : (&ehigh_c ? ehigh_c : ehigh_c + CW'(1));
      goff_c  <= dq_oe ? '0 : (&goff_c ? goff_c : goff_c + CW'(1));
      stab_c  <= (ctl_now != ctl_q) ? CW'(1) : (&stab_c ? stab_c : stab_c + CW'(1));
      ctl_q   <= ctl_now;
    end
  end

  a_r2_strobe_supplies: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_e_n |-> (vpp_en && vcc_sel == VS_PROG && dev_g_n && dq_oe));

  a_r3_strobe_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_e_n) |-> (elow_c >= CW'(T_PMIN) && elow_c <= CW'(T_PMAX)));

  a_r4_setup: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dev_e_n) |-> stab_c >= CW'(T_SETUP));

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dq_oe) |-> ehigh_c >= CW'(T_SETUP));

  a_r4_steady_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_e_n |=> ($stable(dq_out) && $stable(dev_addr) && dq_oe));

  a_r5_read_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_g_n |-> (dev_e_n && !dq_oe));

  a_r5_release_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dev_g_n) |-> goff_c >= CW'(T_SETUP));

  a_r7_pulse_limit: assert property (@(posedge clk) disable iff (!rst_n)
    npulse <= MAXP);

  a_r9_check_supply: assert property (@(posedge clk) disable iff (!rst_n)
    (!dev_g_n && phase != 2'd0) |-> (!vpp_en && (vcc_sel == VS_HI || vcc_sel == VS_LO)));

  a_r10_idle_supply: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (!vpp_en && vcc_sel == VS_NOM));

  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (src_req && !src_valid) |=> (src_req && $stable(src_addr)));

endmodule

// File: tb/eprom_prog_seq_test.sv
`timescale 1ns/1ps
module eprom_prog_seq_test;
  localparam int AW = 3;
  localparam int NB = 1 << AW;
  localparam int KHZ = 10000;          // timing scaled: 1 cycle = 0.1 us
  localparam int MAXP = 25;
  localparam int TP = 1000;            // 100 us
  localparam int TS = 20;              // 2 us
  localparam int TQ = 1;               // 100 ns rounded up

  logic clk = 0, rst_n = 0, start = 0;
  logic done, fail, src_req, src_valid = 0;
  logic [AW-1:0] src_addr, dev_addr, fail_addr;
  logic [7:0] src_data = 0, dq_out, dq_in;
  logic dev_e_n, dev_g_n, vpp_en, dq_oe;
  logic [1:0] vcc_sel, fail_phase;
  logic [4:0] fail_pulses;

  always #2.5 clk = ~clk;

  eprom_prog_seq #(.ADDR_W(AW), .DATA_W(8), .CLK_KHZ(KHZ), .MAX_PULSES(MAXP)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done), .fail(fail),
    .src_req(src_req), .src_addr(src_addr), .src_valid(src_valid), .src_data(src_data),
    .dev_e_n(dev_e_n), .dev_g_n(dev_g_n), .vpp_en(vpp_en), .vcc_sel(vcc_sel),
    .dev_addr(dev_addr), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in),
    .fail_addr(fail_addr), .fail_pulses(fail_pulses), .fail_phase(fail_phase));

  int n_chk = 0, n_fail = 0;
  logic [7:0] image [NB];
  logic [7:0] mem [NB];
  logic [7:0] stuck [NB];
  int need [NB];
  int cnt [NB];
  int weak_addr = -1;
  int elow = 0, gcnt = 0, stab = 0, dly = 0;
  int bad_width = 0, bad_setup = 0, bad_sup = 0, bad_bus = 0, strobes = 0, grants = 0;
  int reads [4];
  logic prev_e = 1, prev_g = 1;
  logic [AW+12:0] prev_ctl = '0;
  logic [7:0] rd_val;

  always_comb begin
    rd_val = mem[dev_addr];
    if (weak_addr == int'(dev_addr) && vcc_sel == 2'd3) rd_val = rd_val ^ 8'h01;
  end
  assign dq_in = (!dev_g_n && dev_e_n && gcnt > TQ) ? rd_val : ~rd_val;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // device model and bus monitor
  initial forever begin
    @(negedge clk);
    if ({dev_addr, dq_out, dq_oe, vpp_en, vcc_sel} != prev_ctl) stab = 0; else stab++;
    prev_ctl = {dev_addr, dq_out, dq_oe, vpp_en, vcc_sel};
    if (!dev_e_n && prev_e) if (stab < TS) bad_setup++;
    if (!dev_e_n && !(vpp_en && vcc_sel == 2'd1 && dev_g_n && dq_oe)) bad_sup++;
    if (dev_e_n && !prev_e) begin
      strobes++;
      if (elow != TP) bad_width++;
      cnt[dev_addr]++;
      if (cnt[dev_addr] >= need[dev_addr]) mem[dev_addr] = mem[dev_addr] & (dq_out | stuck[dev_addr]);
      elow = 0;
    end else if (!dev_e_n) elow++;
    if (!dev_g_n && dq_oe) bad_bus++;
    if (!dev_g_n && prev_g) reads[vcc_sel]++;
    if (!dev_g_n) gcnt++; else gcnt = 0;
    prev_e = dev_e_n;
    prev_g = dev_g_n;
  end

  // byte source
  initial forever begin
    @(negedge clk);
    if (src_req && !src_valid) begin
      if (dly == 0) begin
        src_valid = 1;
        src_data = image[src_addr];
        grants++;
        dly = $urandom % 3;
      end else dly--;
    end else src_valid = 0;
  end

  function automatic int exp_strobes(input int a);
    return (image[a] == 8'hFF) ? 0 : need[a];
  endfunction

  function automatic int exp_prog_reads();
    int s = 0;
    for (int a = 0; a < NB; a++) s += (image[a] == 8'hFF) ? 1 : need[a];
    return s;
  endfunction

  task automatic prep();
    for (int a = 0; a < NB; a++) begin
      mem[a] = 8'hFF; cnt[a] = 0; stuck[a] = 8'h00;
    end
    for (int i = 0; i < 4; i++) reads[i] = 0;
    weak_addr = -1; bad_width = 0; bad_setup = 0; bad_sup = 0; bad_bus = 0;
    strobes = 0; grants = 0;
  endtask

  task automatic run();
    int w = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    while (!done && w < 60000) begin @(negedge clk); w++; end
    chk(done === 1'b1, "R10 watchdog/done", int'(done), 1);
    repeat (2) @(negedge clk);
  endtask

  task automatic check_success(input string tag);
    chk(fail === 1'b0, {"R10 fail flag ", tag}, int'(fail), 0);
    chk(!vpp_en && vcc_sel == 2'd0, {"R10 supplies off ", tag}, int'({vpp_en, vcc_sel}), 0);
    for (int a = 0; a < NB; a++) begin
      chk(mem[a] == image[a], {"R6 array content ", tag}, int'(mem[a]), int'(image[a]));
      chk(cnt[a] == exp_strobes(a), {"R6/R8 strobes per byte ", tag}, cnt[a], exp_strobes(a));
    end
    chk(bad_width == 0, {"R3 strobe width ", tag}, bad_width, 0);
    chk(bad_setup == 0, {"R4 setup ", tag}, bad_setup, 0);
    chk(bad_sup == 0, {"R2 strobe supplies ", tag}, bad_sup, 0);
    chk(bad_bus == 0, {"R5 bus released ", tag}, bad_bus, 0);
    chk(reads[1] == exp_prog_reads(), {"R6 verify count ", tag}, reads[1], exp_prog_reads());
    chk(reads[2] == NB, {"R9 pass at 6.0V ", tag}, reads[2], NB);
    chk(reads[3] == NB, {"R9 pass at 4.2V ", tag}, reads[3], NB);
    chk(grants == 3 * NB, {"R11 source grants ", tag}, grants, 3 * NB);
  endtask

  initial begin
    int seed = 7;
    void'($urandom(seed));
    for (int a = 0; a < NB; a++) begin mem[a] = 8'hFF; stuck[a] = 0; cnt[a] = 0; need[a] = 1; image[a] = 8'hFF; end
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(dev_e_n && dev_g_n && !vpp_en && vcc_sel == 0 && !dq_oe && !src_req && !done && !fail,
        "R1 reset outputs", int'({dev_e_n, dev_g_n, vpp_en, vcc_sel, dq_oe, src_req, done, fail}), 'b110000000);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(dev_e_n && dev_g_n && !vpp_en && !done, "R1 idle after reset", int'({dev_e_n, dev_g_n, vpp_en, done}), 'b1100);

    // random images with directed erased bytes
    for (int k = 0; k < 2; k++) begin
      prep();
      for (int a = 0; a < NB; a++) begin
        image[a] = 8'($urandom);
        need[a] = 1 + ($urandom % 2);
      end
      image[0] = 8'hFF;
      image[NB-1] = 8'h00;
      run();
      check_success($sformatf("random%0d", k));
    end

    // all erased: no strobes at all (R8)
    prep();
    for (int a = 0; a < NB; a++) image[a] = 8'hFF;
    run();
    chk(strobes == 0, "R8 no strobes for 0xFF", strobes, 0);
    chk(!fail && reads[1] == NB, "R8 one verify per erased byte", reads[1], NB);

    // stuck bit: retry limit (R7)
    prep();
    for (int a = 0; a < NB; a++) begin image[a] = 8'($urandom) | 8'h01; need[a] = 1; end
    image[5] = 8'h3C;
    stuck[5] = 8'h01;
    run();
    chk(fail === 1'b1, "R7 fail flag", int'(fail), 1);
    chk(fail_addr == 5, "R7 fail address", int'(fail_addr), 5);
    chk(fail_pulses == MAXP, "R7 fail pulse count", int'(fail_pulses), MAXP);
    chk(fail_phase == 0, "R7 fail phase", int'(fail_phase), 0);
    chk(cnt[5] == MAXP, "R7 strobes on stuck byte", cnt[5], MAXP);
    chk(cnt[6] == 0 && cnt[7] == 0, "R7 later bytes untouched", cnt[6] + cnt[7], 0);
    chk(!vpp_en && vcc_sel == 0, "R7 supplies off", int'({vpp_en, vcc_sel}), 0);

    // low-margin weak byte (R9)
    prep();
    for (int a = 0; a < NB; a++) begin image[a] = 8'($urandom); need[a] = 1; end
    weak_addr = 2;
    run();
    chk(fail === 1'b1, "R9 low-margin fail flag", int'(fail), 1);
    chk(fail_phase == 2, "R9 low-margin phase", int'(fail_phase), 2);
    chk(fail_addr == 2, "R9 low-margin address", int'(fail_addr), 2);
    chk(reads[2] == NB, "R9 high-margin pass complete", reads[2], NB);
    chk(reads[3] == 3, "R9 low-margin pass stops at weak byte", reads[3], 3);
    chk(bad_bus == 0, "R5 bus released during checks", bad_bus, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R10 watchdog expired: actual 0 expected 1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule